// File: doc/BRIEF.md
# SDRAM Read Burst Output Sequencer

This block models the device side of the read data path of a two-bank synchronous DRAM. Each clock it samples one command with a bank select, a row, a column, write data and two byte masks. It keeps a small word array and a record of which row is open in each bank. It then drives the 16-bit data outputs and a per-byte output enable, cycle by cycle, the way the memory would drive its data pins.

A read starts a burst of sequential columns that wrap inside their aligned block. The first word appears after the selected CAS latency. The byte masks gate the output with their own fixed two-clock latency. A burst already in flight can be cut short by a newer read, by a write, or by a precharge of its bank. The CAS latency and burst length codes are static inputs and change only while reset is held.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `dq_oe` is 0, `dq` is 0 and `proto_err` is 0. After reset both banks are closed and the word at array index i = {bank, row, col} (7 bits) reads back as {i, ~i}, each half 8 bits with i zero-extended.
- R2: Command codes on `cmd` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge bank, 5 precharge both; codes 6 and 7 act as no-op. An activate opens the selected bank at `row`. A read or write uses the open row of its bank and ignores `row`.
- R3: `cas_code` 1, 2 or 3 sets the CAS latency L to that many clocks, and code 0 acts as 1. A read sampled at edge N drives its first word in the cycle after edge N+L.
- R4: `bl_code` 0/1/2/3 selects a burst of 1/2/4/8 words. Word k of a burst at start column c is read from the column whose low log2(BL) bits are (c+k) mod BL and whose upper bits equal those of c. Words appear on consecutive cycles.
- R5: A byte mask sampled high at edge N forces that byte's enable low, and its data to zero, in the cycle after edge N+2. This holds whatever the CAS latency.
- R6: A read to an open bank accepted during a burst, to the same or the other bank, replaces it. The older burst's words stop exactly where the new burst's first word appears.
- R7: A precharge of the bursting bank, or a precharge of both banks, sampled at edge P leaves the last older word in the cycle after edge P+L-2, and nothing from edge P+L-1 onward. A precharge of the other bank does not disturb the burst.
- R8: A write sampled at edge W turns both enables off from the cycle after edge W until data from a later read arrives. A write to an open bank stores `din` at {bank, open row, col}.
- R9: A read to a closed bank drives nothing and sets `proto_err`. The flag stays set until reset.
- R10: Each byte of `dq` is zero in any cycle where that byte's enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code sampled each clock |
| bank | input | 1 | Bank select |
| row | input | 2 | Row address for activate |
| col | input | 4 | Start column for read or write |
| din | input | 16 | Word stored by a write |
| mask_hi | input | 1 | Upper byte output mask |
| mask_lo | input | 1 | Lower byte output mask |
| cas_code | input | 2 | CAS latency code (static) |
| bl_code | input | 2 | Burst length code (static) |
| dq | output | 16 | Read data output |
| dq_oe | output | 2 | Per-byte output enable, bit 1 upper |
| proto_err | output | 1 | Sticky read-to-closed-bank flag |

## Verification
A wrong column counter shows up as a wrong word one CAS latency after the bad step, and a wrong wrap shows up at the block boundary inside that same burst. A stale or wrong latency tap moves every burst by whole cycles, so the first cycle of a burst shows it at once. An interrupt that fails to clear the pipeline leaves extra words in the cycles after the interrupting command, up to three cycles late at the longest latency. A mask delay line of the wrong depth leaves the enables off one cycle early or late next to a burst.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

    localparam int BANK_W   = 1;
    localparam int NBANK    = 1 << BANK_W;
    localparam int ROW_W    = 2;
    localparam int COL_W    = 4;
    localparam int DQ_W     = 16;
    localparam int NBYTE    = DQ_W / 8;
    localparam int ADDR_W   = BANK_W + ROW_W + COL_W;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int CL_MAX   = 3;
    localparam int MASK_LAT = 2;
    localparam int IDX_W    = 3;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PALL = 3'd5
    } cmd_e;

    // One column address produced per clock by the burst engine
    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } beat_t;

    // One slot of the CAS latency delay line
    typedef struct packed {
        logic            valid;
        logic [DQ_W-1:0] data;
    } stage_t;

    function automatic logic [IDX_W:0] burst_words(input logic [1:0] code);
        return (IDX_W+1)'(1) << code;
    endfunction

    function automatic logic [1:0] cas_cycles(input logic [1:0] code);
        return (code == 2'd0) ? 2'd1 : code;
    endfunction

    function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx,
                                                  input logic [1:0]       code);
        logic [COL_W-1:0] low_mask;
        low_mask = COL_W'(burst_words(code) - (IDX_W+1)'(1));
        return (base & ~low_mask) | ((base + COL_W'(idx)) & low_mask);
    endfunction

    function automatic logic [DQ_W-1:0] init_word(input logic [ADDR_W-1:0] a);
        logic [7:0] b;
        b = 8'(a);
        return {b, ~b};
    endfunction

endpackage

// File: rtl/sdr_bank_ctl.sv
module sdr_bank_ctl
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row_in,
    output logic              rd_go,
    output logic              wr_go,
    output logic [ROW_W-1:0]  cur_row,
    output logic              err
);

    logic [NBANK-1:0] open_vec;
    logic [ROW_W-1:0] row_arr [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic             is_open;
        logic [ROW_W-1:0] row_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                is_open <= 1'b0;
                row_q   <= '0;
            end else begin
                unique case (cmd)
                    CMD_ACT: if (bank == BANK_W'(g)) begin
                        is_open <= 1'b1;
                        row_q   <= row_in;
                    end
                    CMD_PRE: if (bank == BANK_W'(g)) is_open <= 1'b0;
                    CMD_PALL: is_open <= 1'b0;
                    default: ;
                endcase
            end
        end

        assign open_vec[g] = is_open;
        assign row_arr[g]  = row_q;
    end

    assign rd_go   = (cmd == CMD_RD) && open_vec[bank];
    assign wr_go   = (cmd == CMD_WR) && open_vec[bank];
    assign cur_row = row_arr[bank];

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if ((cmd == CMD_RD) && !open_vec[bank])
            err <= 1'b1;
    end

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    a_r9_closed_read_flags: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_RD) && !open_vec[bank]) |=> err);

    a_r2_activate_opens: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |=> open_vec[$past(bank)]);

endmodule

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  cur_row,
    input  logic              rd_go,
    input  logic [1:0]        bl_code,
    output beat_t             beat,
    output logic              kill
);

    logic              act_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pre_hit;
    logic              stop;
    logic              last;

    assign pre_hit = act_q && (((cmd == CMD_PRE) && (bank == bank_q)) || (cmd == CMD_PALL));
    assign stop    = pre_hit || (cmd == CMD_WR);
    assign last    = ((IDX_W+1)'(idx_q) == (burst_words(bl_code) - (IDX_W+1)'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            idx_q  <= '0;
        end else if (rd_go) begin
            act_q  <= 1'b1;
            bank_q <= bank;
            row_q  <= cur_row;
            col_q  <= col;
            idx_q  <= '0;
        end else if (stop) begin
            act_q  <= 1'b0;
        end else if (act_q) begin
            if (last)
                act_q <= 1'b0;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        beat.valid = act_q;
        beat.bank  = bank_q;
        beat.row   = row_q;
        beat.col   = wrap_col(col_q, idx_q, bl_code);
    end

    // The word fetched on the precharge clock is dropped before it enters the delay line
    assign kill = pre_hit;

    a_r7_pall_stops_engine: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PALL) |=> !beat.valid);

    a_r6_read_restarts: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> (beat.valid && (beat.col == $past(col))));

endmodule

// File: rtl/sdr_store.sv
module sdr_store
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DQ_W-1:0]   wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DQ_W-1:0]   rdata
);

    logic [DQ_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= init_word(ADDR_W'(i));
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sdr_out_pipe.sv
module sdr_out_pipe
    import sdr_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_valid,
    input  logic [DQ_W-1:0]  rdata,
    input  logic             kill,
    input  logic             flush,
    input  logic [NBYTE-1:0] mask,
    input  logic [1:0]       cas_code,
    output logic [DQ_W-1:0]  dq,
    output logic [NBYTE-1:0] oe
);

    stage_t           st [CL_MAX];
    logic [NBYTE-1:0] mp [MASK_LAT+1];
    logic [1:0]       tap;
    stage_t           sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CL_MAX; i++)
                st[i] <= '0;
            for (int j = 0; j <= MASK_LAT; j++)
                mp[j] <= '0;
        end else begin
            st[0].valid <= beat_valid & ~kill & ~flush;
            st[0].data  <= rdata;
            for (int i = 1; i < CL_MAX; i++) begin
                st[i].valid <= st[i-1].valid & ~flush;
                st[i].data  <= st[i-1].data;
            end
            mp[0] <= mask;
            for (int j = 1; j <= MASK_LAT; j++)
                mp[j] <= mp[j-1];
        end
    end

    assign tap = cas_cycles(cas_code) - 2'd1;
    assign sel = st[tap];

    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        assign oe[g]         = sel.valid & ~mp[MASK_LAT][g];
        assign dq[g*8 +: 8]  = oe[g] ? sel.data[g*8 +: 8] : 8'h00;
    end

    a_r8_write_blanks: assert property (@(posedge clk) disable iff (rst)
        flush |=> (oe == '0));

    a_r5_mask_lo_gap: assert property (@(posedge clk) disable iff (rst)
        mask[0] |-> ##3 !oe[0]);

    a_r5_mask_hi_gap: assert property (@(posedge clk) disable iff (rst)
        mask[NBYTE-1] |-> ##3 !oe[NBYTE-1]);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DQ_W-1:0]   din,
    input  logic              mask_hi,
    input  logic              mask_lo,
    input  logic [1:0]        cas_code,
    input  logic [1:0]        bl_code,
    output logic [DQ_W-1:0]   dq,
    output logic [NBYTE-1:0]  dq_oe,
    output logic              proto_err
);

    cmd_e             cmd_c;
    logic             rd_go;
    logic             wr_go;
    logic [ROW_W-1:0] cur_row;
    beat_t            beat;
    logic             kill;
    logic [DQ_W-1:0]  rdata;

    assign cmd_c = cmd_e'(cmd);

    sdr_bank_ctl i_bank (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd_c),
        .bank    (bank),
        .row_in  (row),
        .rd_go   (rd_go),
        .wr_go   (wr_go),
        .cur_row (cur_row),
        .err     (proto_err)
    );

    sdr_burst_gen i_burst (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd_c),
        .bank    (bank),
        .col     (col),
        .cur_row (cur_row),
        .rd_go   (rd_go),
        .bl_code (bl_code),
        .beat    (beat),
        .kill    (kill)
    );

    sdr_store i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_go),
        .waddr ({bank, cur_row, col}),
        .wdata (din),
        .raddr ({beat.bank, beat.row, beat.col}),
        .rdata (rdata)
    );

    sdr_out_pipe i_out (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (beat.valid),
        .rdata      (rdata),
        .kill       (kill),
        .flush      (cmd_c == CMD_WR),
        .mask       ({mask_hi, mask_lo}),
        .cas_code   (cas_code),
        .dq         (dq),
        .oe         (dq_oe)
    );

endmodule

// File: tb/test_sdram_rd_seq.sv
`timescale 1ns/100ps
module test_sdram_rd_seq;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_WR = 3'd3, C_PRE = 3'd4, C_PALL = 3'd5;

    typedef struct packed {
        logic [2:0]  c;
        logic        b;
        logic [1:0]  r;
        logic [3:0]  co;
        logic [15:0] d;
        logic        mh;
        logic        ml;
        logic [1:0]  eoe;
        logic [15:0] edq;
        logic [3:0]  req;
    } vec_t;

    // CAS latency 2, burst length 4
    localparam vec_t TBL [35] = '{
        '{C_ACT, 1'b0, 2'd1, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd2},  // R2
        '{C_ACT, 1'b1, 2'd2, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd2},  // R2
        '{C_RD,  1'b0, 2'd0, 4'd2,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd3},  // R3
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd3},  // R3
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h12ED, 4'd3},  // R3
        '{C_RD,  1'b1, 2'd3, 4'd13, 16'h0, 1'b0, 1'b0, 2'b11, 16'h13EC, 4'd4},  // R4
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h10EF, 4'd4},  // R4 wrap
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h6D92, 4'd6},  // R6
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b1, 1'b0, 2'b11, 16'h6E91, 4'd6},  // R6
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b1, 2'b11, 16'h6F90, 4'd6},  // R6
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b01, 16'h0093, 4'd5},  // R5 R10
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd5},  // R5
        '{C_RD,  1'b0, 2'd0, 4'd5,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd7},  // R7
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd7},  // R7
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h15EA, 4'd7},  // R7
        '{C_PRE, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h16E9, 4'd7},  // R7
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd7},  // R7
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd7},  // R7
        '{C_RD,  1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd9},  // R9
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd9},  // R9
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd9},  // R9
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd9},  // R9
        '{C_RD,  1'b1, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd8},  // R8
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd8},  // R8
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h609F, 4'd8},  // R8
        '{C_WR,  1'b1, 2'd0, 4'd8, 16'hBEEF, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd8}, // R8
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd8},  // R8
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd8},  // R8
        '{C_RD,  1'b1, 2'd0, 4'd8,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd8},  // R8
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd8},  // R8
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'hBEEF, 4'd8},  // R8 stored word
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h6996, 4'd4},  // R4
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h6A95, 4'd4},  // R4
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b11, 16'h6B94, 4'd4},  // R4
        '{C_NOP, 1'b0, 2'd0, 4'd0,  16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cmd;
    logic        bank;
    logic [1:0]  row;
    logic [3:0]  col;
    logic [15:0] din;
    logic        mask_hi, mask_lo;
    logic [1:0]  cas_code, bl_code;
    logic [15:0] dq;
    logic [1:0]  dq_oe;
    logic        proto_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sdram_rd_seq i_sdram_rd_seq (
        .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .row(row), .col(col),
        .din(din), .mask_hi(mask_hi), .mask_lo(mask_lo), .cas_code(cas_code),
        .bl_code(bl_code), .dq(dq), .dq_oe(dq_oe), .proto_err(proto_err)
    );

    // Called at a falling edge: drive, pass one rising edge, compare at the next falling edge
    task automatic step(input logic [2:0] c, input logic b, input logic [1:0] r,
                        input logic [3:0] co, input logic [15:0] d, input logic mh,
                        input logic ml, input logic [1:0] eoe, input logic [15:0] edq,
                        input string tag);
        cmd = c; bank = b; row = r; col = co; din = d; mask_hi = mh; mask_lo = ml;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (dq_oe !== eoe || dq !== edq) begin
            failures++;
            $display("FAIL %s t=%0t oe=%b dq=%h expected oe=%b dq=%h", tag, $time, dq_oe, dq, eoe, edq);
        end
    endtask

    task automatic check_err(input logic exp, input string tag);
        checks++;
        if (proto_err !== exp) begin
            failures++;
            $display("FAIL %s proto_err=%b expected %b", tag, proto_err, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if (dq_oe !== 2'b00 || dq !== 16'h0 || proto_err !== 1'b0) begin
            failures++;
            $display("FAIL %s oe=%b dq=%h err=%b expected oe=00 dq=0000 err=0", tag, dq_oe, dq, proto_err);
        end
    endtask

    task automatic do_reset(input logic [1:0] cl, input logic [1:0] bl);
        rst = 1'b1; cmd = C_NOP; mask_hi = 1'b0; mask_lo = 1'b0;
        cas_code = cl; bl_code = bl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1 during reset");
        rst = 1'b0;
    endtask

    task automatic nop(input logic [1:0] eoe, input logic [15:0] edq, input string tag);
        step(C_NOP, 1'b0, 2'd0, 4'd0, 16'h0, 1'b0, 1'b0, eoe, edq, tag);
    endtask

    initial begin
        cmd = C_NOP; bank = 1'b0; row = '0; col = '0; din = '0;
        mask_hi = 1'b0; mask_lo = 1'b0; rst = 1'b1;
        @(negedge clk);
        do_reset(2'd2, 2'd2);

        for (int i = 0; i < 35; i++)
            step(TBL[i].c, TBL[i].b, TBL[i].r, TBL[i].co, TBL[i].d, TBL[i].mh, TBL[i].ml,
                 TBL[i].eoe, TBL[i].edq, $sformatf("R%0d table step %0d", TBL[i].req, i));
        check_err(1'b1, "R9 sticky after closed-bank read");

        // R7 other-bank precharge, R4 burst of 8 with wrap, R3 latency 3
        do_reset(2'd3, 2'd3);
        check_err(1'b0, "R1 flag cleared by reset");
        step(C_ACT, 1'b0, 2'd0, 4'd0, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, "R2");
        step(C_ACT, 1'b1, 2'd3, 4'd0, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, "R2");
        step(C_RD,  1'b0, 2'd0, 4'd6, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, "R3");
        nop(2'b00, 16'h0000, "R3 latency 3 early");
        nop(2'b00, 16'h0000, "R3 latency 3 early");
        step(C_PRE, 1'b1, 2'd0, 4'd0, 16'h0, 1'b0, 1'b0, 2'b11, 16'h06F9, "R3 first word");
        nop(2'b11, 16'h07F8, "R7 other bank keeps burst");
        nop(2'b11, 16'h00FF, "R4 wrap to column 0");
        nop(2'b11, 16'h01FE, "R4");
        nop(2'b11, 16'h02FD, "R4");
        nop(2'b11, 16'h03FC, "R4");
        nop(2'b11, 16'h04FB, "R4");
        nop(2'b11, 16'h05FA, "R4 eighth word");
        nop(2'b00, 16'h0000, "R4 burst of 8 ends");

        // R3 latency 1, R4 burst of 1
        do_reset(2'd1, 2'd0);
        step(C_ACT, 1'b1, 2'd1, 4'd0, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, "R2");
        step(C_RD,  1'b1, 2'd0, 4'd9, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, "R3");
        nop(2'b11, 16'h59A6, "R3 latency 1");
        nop(2'b00, 16'h0000, "R4 burst of 1");

        // R3 code 0 acts as 1, R7 precharge-both at latency 1
        do_reset(2'd0, 2'd3);
        step(C_ACT, 1'b0, 2'd2, 4'd0, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, "R2");
        step(C_RD,  1'b0, 2'd0, 4'd3, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, "R3");
        nop(2'b11, 16'h23DC, "R3 code 0");
        nop(2'b11, 16'h24DB, "R7 last word before precharge");
        step(C_PALL, 1'b0, 2'd0, 4'd0, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0000, "R7 precharge both");
        nop(2'b00, 16'h0000, "R7 stays off");
        check_err(1'b0, "R9 no flag without closed-bank read");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule